// File: doc/BRIEF.md
# Selectable Video Test Pattern Generator

This block sits in a pixel stream directly behind a video timing generator. Each clock it receives one pixel slot: vertical and horizontal sync, a data-enable flag, the active-area coordinates of the pixel and a default colour. An 8-bit select code chooses one of five synthetic images, or lets the default colour through. The five images are a border frame, stripes along X, stripes along Y, a horizontal grey ramp and an XOR texture.

The active width and height come in as inputs, so one instance can serve any video format. The ramp is a fixed-point accumulator with 12 fractional bits. Its per-pixel increment is supplied by the integrator as full scale (0xFFFFF) divided by the active width, for example 0x0222 for 1920 pixels or 0x0333 for 1280. For interlaced formats the height input is the sum of the active lines of both fields.

The block has a single register stage. Sync, enable and colour leave together one clock after they enter.

Top module: `vid_pattern_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, all outputs are zero.
- R2: out_vs, out_hs and out_de equal in_vs, in_hs and in_de of the previous clock.
- R3: When the previous clock had in_de low, out_r, out_g and out_b are all zero, whatever the select code.
- R4: Select 1 (border): the pixel is white (0xFF on all channels) if x is 0, x is act_pixels-1, y is 0 or y is act_lines-1, and black otherwise.
- R5: Select 2 (stripes along X): even x gives white and odd x gives black.
- R6: Select 3 (stripes along Y): even y gives white and odd y gives black.
- R7: Select 4 (ramp): a 20-bit accumulator with 12 fractional bits is zero at the first pixel of each run of in_de. It gains ramp_step after every enabled pixel and wraps modulo 2^20. All three channels show its bits [19:12]. The accumulator runs on every enabled pixel whatever the select code, so a switch to select 4 in the middle of a line shows the value for that position.
- R8: Select 5 (XOR): out_r and out_g are the low 8 bits of x XOR y, and out_b is zero.
- R9: Select 0 and selects 6 to 255 pass dflt_r, dflt_g and dflt_b through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 8 | Pattern select code |
| in_vs | input | 1 | Vertical sync in |
| in_hs | input | 1 | Horizontal sync in |
| in_de | input | 1 | Data enable in |
| pos_x | input | 12 | Active pixel column |
| pos_y | input | 12 | Active line row |
| act_pixels | input | 12 | Active pixels per line |
| act_lines | input | 12 | Active lines per frame |
| ramp_step | input | 20 | Ramp increment per pixel, 12 fractional bits |
| dflt_r | input | 8 | Default red |
| dflt_g | input | 8 | Default green |
| dflt_b | input | 8 | Default blue |
| out_vs | output | 1 | Delayed vertical sync |
| out_hs | output | 1 | Delayed horizontal sync |
| out_de | output | 1 | Delayed data enable |
| out_r | output | 8 | Red out |
| out_g | output | 8 | Green out |
| out_b | output | 8 | Blue out |

## Verification
The assertions assume the following about the inputs:
- pos_x and pos_y are zero-based active coordinates whenever in_de is high.
- act_pixels and act_lines are nonzero.
- in_de drops between lines, so every line starts a new enable run.

The stimulus is built from whole small frames: a 16x6 and a 12x5 active area, with horizontal and vertical blanking in which hs and vs pulse. These frames are driven with every defined select code and with several out-of-range codes. A further frame alternates between stripes and ramp from line to line, to show that the accumulator keeps running. The ramp steps cover an exact full-scale fit, a small step and a step that forces the accumulator to wrap.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
    localparam logic [7:0] PAT_BORDER  = 8'd1;
    localparam logic [7:0] PAT_STRIPEX = 8'd2;
    localparam logic [7:0] PAT_STRIPEY = 8'd3;
    localparam logic [7:0] PAT_RAMP    = 8'd4;
    localparam logic [7:0] PAT_XOR     = 8'd5;

    typedef struct packed {
        logic vs;
        logic hs;
        logic de;
    } sync_t;
endpackage

// File: rtl/vpg_ramp_acc.sv
module vpg_ramp_acc #(
    parameter int ACC_W  = 20,
    parameter int FRAC_W = 12,
    parameter int CW     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de,
    input  logic [ACC_W-1:0] step,
    output logic [CW-1:0]    level
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             de_prev;
    } ramp_t;

    ramp_t r_d, r_q;

    // accumulator holds the value of the current pixel; cleared whenever enable is low
    always_comb begin
        r_d.de_prev = de;
        r_d.acc     = de ? r_q.acc + step : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign level = r_q.acc[FRAC_W +: CW];

    // R7: first pixel of an enable run sees a cleared accumulator
    p_ramp_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de && !r_q.de_prev) |-> (level == '0));
endmodule

// File: rtl/vpg_shape.sv
module vpg_shape
    import vpg_pkg::*;
#(
    parameter int CW = 8,
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic [7:0]      sel,
    input  logic            de,
    input  logic [XW-1:0]   pos_x,
    input  logic [YW-1:0]   pos_y,
    input  logic [XW-1:0]   act_pixels,
    input  logic [YW-1:0]   act_lines,
    input  logic [3*CW-1:0] dflt,
    input  logic [CW-1:0]   ramp_lvl,
    output logic [3*CW-1:0] rgb
);
    localparam logic [XW-1:0] ONE_X = XW'(1);
    localparam logic [YW-1:0] ONE_Y = YW'(1);
    localparam logic [CW-1:0] WHITE = '1;

    logic [CW-1:0] ch_d [3];
    logic [XW-1:0] xy;
    logic          on_edge;

    always_comb begin
        xy      = pos_x ^ XW'(pos_y);
        on_edge = (pos_x == '0) || (pos_x == act_pixels - ONE_X) ||
                  (pos_y == '0) || (pos_y == act_lines - ONE_Y);
        for (int c = 0; c < 3; c++) ch_d[c] = dflt[(2-c)*CW +: CW];
        case (sel)
            PAT_BORDER:  for (int c = 0; c < 3; c++) ch_d[c] = on_edge ? WHITE : '0;
            PAT_STRIPEX: for (int c = 0; c < 3; c++) ch_d[c] = pos_x[0] ? '0 : WHITE;
            PAT_STRIPEY: for (int c = 0; c < 3; c++) ch_d[c] = pos_y[0] ? '0 : WHITE;
            PAT_RAMP:    for (int c = 0; c < 3; c++) ch_d[c] = ramp_lvl;
            PAT_XOR: begin
                ch_d[0] = xy[CW-1:0];
                ch_d[1] = xy[CW-1:0];
                ch_d[2] = '0;
            end
            default: ;
        endcase
    end

    // channel 0 red in the top slice, blanked outside the active area
    for (genvar c = 0; c < 3; c++) begin : g_chan
        assign rgb[(2-c)*CW +: CW] = de ? ch_d[c] : '0;
    end
endmodule

// File: rtl/vid_pattern_gen.sv
module vid_pattern_gen
    import vpg_pkg::*;
#(
    parameter int CW     = 8,
    parameter int XW     = 12,
    parameter int YW     = 12,
    parameter int ACC_W  = 20,
    parameter int FRAC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       sel,
    input  logic             in_vs,
    input  logic             in_hs,
    input  logic             in_de,
    input  logic [XW-1:0]    pos_x,
    input  logic [YW-1:0]    pos_y,
    input  logic [XW-1:0]    act_pixels,
    input  logic [YW-1:0]    act_lines,
    input  logic [ACC_W-1:0] ramp_step,
    input  logic [CW-1:0]    dflt_r,
    input  logic [CW-1:0]    dflt_g,
    input  logic [CW-1:0]    dflt_b,
    output logic             out_vs,
    output logic             out_hs,
    output logic             out_de,
    output logic [CW-1:0]    out_r,
    output logic [CW-1:0]    out_g,
    output logic [CW-1:0]    out_b
);
    localparam int PW = 3 * CW;

    typedef struct packed {
        logic          past_ok;
        sync_t         sync;
        logic [PW-1:0] rgb;
    } stage_t;

    stage_t        st_d, st_q;
    logic [CW-1:0] ramp_lvl;
    logic [PW-1:0] shade;

    vpg_ramp_acc #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .CW(CW)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .de    (in_de),
        .step  (ramp_step),
        .level (ramp_lvl)
    );

    vpg_shape #(.CW(CW), .XW(XW), .YW(YW)) u_shape (
        .sel        (sel),
        .de         (in_de),
        .pos_x      (pos_x),
        .pos_y      (pos_y),
        .act_pixels (act_pixels),
        .act_lines  (act_lines),
        .dflt       ({dflt_r, dflt_g, dflt_b}),
        .ramp_lvl   (ramp_lvl),
        .rgb        (shade)
    );

    always_comb begin
        st_d.past_ok = 1'b1;
        st_d.sync.vs = in_vs;
        st_d.sync.hs = in_hs;
        st_d.sync.de = in_de;
        st_d.rgb     = shade;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vs = st_q.sync.vs;
    assign out_hs = st_q.sync.hs;
    assign out_de = st_q.sync.de;
    assign out_r  = st_q.rgb[2*CW +: CW];
    assign out_g  = st_q.rgb[CW +: CW];
    assign out_b  = st_q.rgb[0 +: CW];

    // R2: sync and enable leave one clock after they enter
    p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.past_ok |-> (out_vs == $past(in_vs) && out_hs == $past(in_hs) &&
                          out_de == $past(in_de)));

    // R3: no colour outside the active area
    p_blank_black_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_r == '0 && out_g == '0 && out_b == '0));

    // R5: stripes along X follow the parity of the column
    p_stripe_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_ok && $past(in_de) && $past(sel) == PAT_STRIPEX) |->
        (out_g == ($past(pos_x[0]) ? '0 : {CW{1'b1}})));

    // R7: the ramp is grey
    p_ramp_grey_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_ok && $past(in_de) && $past(sel) == PAT_RAMP) |->
        (out_r == out_g && out_g == out_b));

    // R8: XOR image has no blue
    p_xor_blue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_ok && $past(in_de) && $past(sel) == PAT_XOR) |->
        (out_b == '0 && out_r == out_g));

    // R9: unknown codes pass the default colour
    p_default_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_ok && $past(in_de) && ($past(sel) == 8'd0 || $past(sel) > PAT_XOR)) |->
        (out_r == $past(dflt_r) && out_g == $past(dflt_g) && out_b == $past(dflt_b)));
endmodule

// File: tb/sim_vid_pattern_gen.sv
module sim_vid_pattern_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sel = '0;
    logic        in_vs = 0, in_hs = 0, in_de = 0;
    logic [11:0] pos_x = '0, pos_y = '0, act_pixels = 12'd16, act_lines = 12'd6;
    logic [19:0] ramp_step = '0;
    logic [7:0]  dflt_r = '0, dflt_g = '0, dflt_b = '0;
    logic        out_vs, out_hs, out_de;
    logic [7:0]  out_r, out_g, out_b;

    vid_pattern_gen u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    int acc = 0;
    logic       e_vs = 0, e_hs = 0, e_de = 0;
    logic [7:0] e_r = 0, e_g = 0, e_b = 0;
    string      e_tag = "R1";

    task automatic compare();
        vectors++;
        if ({out_vs, out_hs, out_de} !== {e_vs, e_hs, e_de}) begin
            miscompares++;
            $display("FAIL R2 sync: got vs/hs/de=%b%b%b exp %b%b%b", out_vs, out_hs, out_de,
                     e_vs, e_hs, e_de);
        end
        if ({out_r, out_g, out_b} !== {e_r, e_g, e_b}) begin
            miscompares++;
            $display("FAIL %s colour: got %h_%h_%h exp %h_%h_%h", e_tag, out_r, out_g, out_b,
                     e_r, e_g, e_b);
        end
    endtask

    // one pixel slot: check previous result, apply new inputs, predict next result
    task automatic slot(input bit rn, input logic [7:0] s, input bit vs, input bit hs,
                        input bit de, input int x, input int y);
        @(negedge clk);
        compare();
        rst_n = rn; sel = s; in_vs = vs; in_hs = hs; in_de = de;
        pos_x = 12'(x); pos_y = 12'(y);
        if (!rn) begin
            {e_vs, e_hs, e_de, e_r, e_g, e_b} = '0; e_tag = "R1"; acc = 0;
        end else begin
            int lvl;
            {e_vs, e_hs, e_de} = {vs, hs, de};
            lvl = (acc >> 12) & 255;
            if (!de) begin
                {e_r, e_g, e_b} = '0; e_tag = "R3"; acc = 0;
            end else begin
                case (s)
                    8'd1: begin
                        e_tag = "R4";
                        e_r = (x == 0 || x == int'(act_pixels) - 1 || y == 0 ||
                               y == int'(act_lines) - 1) ? 8'hFF : 8'h00;
                        e_g = e_r; e_b = e_r;
                    end
                    8'd2: begin e_tag = "R5"; e_r = (x % 2 == 0) ? 8'hFF : 8'h00; e_g = e_r; e_b = e_r; end
                    8'd3: begin e_tag = "R6"; e_r = (y % 2 == 0) ? 8'hFF : 8'h00; e_g = e_r; e_b = e_r; end
                    8'd4: begin e_tag = "R7"; e_r = 8'(lvl); e_g = e_r; e_b = e_r; end
                    8'd5: begin e_tag = "R8"; e_r = 8'((x ^ y) & 255); e_g = e_r; e_b = 8'h00; end
                    default: begin e_tag = "R9"; e_r = dflt_r; e_g = dflt_g; e_b = dflt_b; end
                endcase
                acc = (acc + int'(ramp_step)) % (1 << 20);
            end
        end
    endtask

    // small frame; even lines use sa, odd lines use sb
    task automatic frame(input logic [7:0] sa, input logic [7:0] sb, input int pix,
                         input int lines, input logic [19:0] step);
        act_pixels = 12'(pix); act_lines = 12'(lines); ramp_step = step;
        for (int l = 0; l < lines + 2; l++)
            for (int c = 0; c < pix + 6; c++)
                slot(1'b1, (l % 2 == 0) ? sa : sb, l == lines + 1,
                     c == pix + 1 || c == pix + 2, l < lines && c < pix, c, l);
    endtask

    initial begin
        dflt_r = 8'h12; dflt_g = 8'hA5; dflt_b = 8'h7E;
        // R1: reset holds outputs at zero despite active input
        for (int i = 0; i < 6; i++) slot(1'b0, 8'd5, 1, 1, 1, i + 3, 1);
        frame(8'd1, 8'd1, 16, 6, 20'h0FFFF);       // R4
        frame(8'd1, 8'd1, 12, 5, 20'h0FFFF);       // R4 other size
        frame(8'd2, 8'd2, 16, 6, 20'h0FFFF);       // R5
        frame(8'd3, 8'd3, 16, 6, 20'h0FFFF);       // R6
        frame(8'd4, 8'd4, 16, 6, 20'h0FFFF);       // R7 full-scale fit
        frame(8'd4, 8'd4, 16, 6, 20'h00333);       // R7 small step
        frame(8'd4, 8'd4, 16, 6, 20'h31000);       // R7 wrap
        frame(8'd2, 8'd4, 16, 6, 20'h0FFFF);       // R7 runs under other select
        frame(8'd5, 8'd5, 16, 6, 20'h0FFFF);       // R8
        frame(8'd0, 8'd6, 16, 6, 20'h0FFFF);       // R9
        dflt_r = 8'hC3; dflt_g = 8'h01; dflt_b = 8'hFE;
        frame(8'd255, 8'd9, 12, 5, 20'h0FFFF);     // R9 other codes
        for (int i = 0; i < 3; i++) slot(1'b0, 8'd4, 0, 0, 1, 0, 0); // R1 again
        slot(1'b1, 8'd0, 0, 0, 0, 0, 0);
        @(negedge clk); compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got no end, exp end of stimulus");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule